// File: doc/BRIEF.md
# NAND Flash Bus Cycle Adapter

This block sits between a processor-side memory port and a bank of NAND flash devices. Each host request is one access of up to one host word. The block turns it into a series of byte-wide flash bus cycles. Bits of the request address select the kind of cycle: a command latch cycle (CLE high), an address latch cycle (ALE high) or a plain data cycle. The two lowest address bits play no part in this choice. A word access is split into byte cycles, least significant byte first, and the host is held off until the last byte cycle has completed.

Requests use a valid/ready handshake. The host raises `host_valid` and holds every request field steady until it sees `host_ready` high at a rising clock edge. `host_ready` stays low for the whole access, and this low level is the wait signal. Completion is a one-cycle pulse on `host_rsp_valid`, which for reads carries the assembled word. That pulse has no back-pressure, so the host must take it in the cycle it appears. Up to four primary chip enables are driven, one per access. A nonzero chip index ORs a secondary-select bit into the flash-side address, which serves multi-die packages. The shared wire-AND ready/busy line is synchronised and exposed as a status bit.

Top module: `nand_cycle_adapter`

## Requirements
- R1: Each byte cycle's latch type is decoded from the request address. If bit 4 is set, CLE is high and ALE is low. Otherwise, if bit 3 is set, ALE is high and CLE is low. If neither bit is set, both are low. CLE and ALE are never high together.
- R2: Address bits 1:0 have no effect. `nand_addr[1:0]` reads 0, and the latch type does not depend on them.
- R3: `host_size` gives the number of byte cycles: 0 gives 1, 1 gives 2, and 2 or 3 gives 4. Byte cycle i carries bits 8i+7:8i of `host_wdata`, in increasing order of i.
- R4: For the whole access, exactly one chip enable is low: `nand_ce_n[host_cs]`. All chip enables are high while the block is idle.
- R5: `nand_addr` equals the request address with bits 1:0 cleared. Bit SEC_BIT (default 14) is additionally set whenever `host_chip` is nonzero.
- R6: Each byte cycle lasts SETUP+STROBE+HOLD clocks (default 1+2+1). During the STROBE clocks, `nand_we_n` is low on writes and `nand_re_n` is low on reads. The two strobes are never low together, and `nand_doe` is high only during writes.
- R7: On a read, the byte present on `nand_din` at the last strobe clock of cycle i goes to bits 8i+7:8i of `host_rdata`, which is therefore little-endian. Lanes that were not read are 0.
- R8: `host_ready` is low from the accepting edge for 4 clocks per byte cycle at default timing. `host_rsp_valid` is high for exactly the first cycle in which `host_ready` is high again.
- R9: `stat_ready` follows `nand_rb`, where 1 means ready and 0 means busy, two clock edges later.
- R10: While reset is held, the block is idle. `host_ready` is 1, every chip enable and strobe is high, and CLE, ALE, `nand_doe` and `host_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request valid |
| host_ready | output | 1 | Request accepted; low means wait |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 half, 2/3 word |
| host_addr | input | AW | Byte address of request |
| host_wdata | input | 8*HOST_BYTES | Write data |
| host_cs | input | $clog2(NUM_CS) | Primary chip select index |
| host_chip | input | 2 | Chip index within package |
| host_rsp_valid | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8*HOST_BYTES | Assembled read data |
| nand_ce_n | output | NUM_CS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_addr | output | AW | Flash-side address with secondary select |
| nand_dout | output | 8 | Byte driven on writes |
| nand_doe | output | 1 | Data output enable |
| nand_din | input | 8 | Byte returned on reads |
| nand_rb | input | 1 | Shared ready/busy, 1 = ready |
| stat_ready | output | 1 | Synchronised ready status |

## Verification
The hardest case to bring about from the ports is a read lane that is wrong but looks right: a byte sampled one clock early or late, or placed into the wrong slot of `host_rdata`. A fixed flash value would hide either mistake. The bench therefore models a device that presents a new byte after every read strobe. Any shift in sampling time or lane index then produces a different word. The stimulus table also uses addresses with both latch bits set and nonzero low bits, so that decode priority and the ignored bits are exercised in the same access.

// File: rtl/nca_pkg.sv
package nca_pkg;
  typedef enum logic [1:0] {
    LAT_DATA = 2'd0,
    LAT_ADDR = 2'd1,
    LAT_CMD  = 2'd2
  } latch_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/nca_decode.sv
module nca_decode
  import nca_pkg::*;
#(
  parameter int AW      = 16,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4
) (
  input  logic [AW-1:2] word_addr,
  output latch_e        kind
);
  always_comb begin
    if (word_addr[CLE_BIT])      kind = LAT_CMD;
    else if (word_addr[ALE_BIT]) kind = LAT_ADDR;
    else                         kind = LAT_DATA;
  end
endmodule

// File: rtl/nca_seq.sv
module nca_seq
  import nca_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int SETUP      = 1,
  parameter int STROBE     = 2,
  parameter int HOLD       = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [$clog2(HOST_BYTES)-1:0]  last_in,
  output phase_e                         phase,
  output logic [$clog2(HOST_BYTES)-1:0]  lane,
  output logic                           sample,
  output logic                           done
);
  localparam int LW   = $clog2(HOST_BYTES);
  localparam int MAXP = (SETUP > STROBE) ? ((SETUP > HOLD) ? SETUP : HOLD)
                                         : ((STROBE > HOLD) ? STROBE : HOLD);
  localparam int CW   = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [CW-1:0] SETUP_M1  = CW'(SETUP - 1);
  localparam logic [CW-1:0] STROBE_M1 = CW'(STROBE - 1);
  localparam logic [CW-1:0] HOLD_M1   = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic [LW-1:0] lane_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lane      <= '0;
      lane_last <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_SETUP;
          cnt       <= SETUP_M1;
          lane      <= '0;
          lane_last <= last_in;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= STROBE_M1;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= HOLD_M1;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          if (lane == lane_last) phase <= PH_IDLE;
          else begin
            lane  <= lane + 1'b1;
            phase <= PH_SETUP;
            cnt   <= SETUP_M1;
          end
        end else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sample = (phase == PH_STROBE) && (cnt == '0);
  assign done   = (phase == PH_HOLD) && (cnt == '0) && (lane == lane_last);

  assert_lane_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (lane <= lane_last));
  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase == PH_IDLE));
  assert_strobe_follows_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_STROBE) |-> $past(phase) == PH_SETUP);
endmodule

// File: rtl/nca_rb_sync.sv
module nca_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);
  logic stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= 1'b0;
      rb_sync <= 1'b0;
    end else begin
      stage1  <= rb_async;
      rb_sync <= stage1;
    end
  end
endmodule

// File: rtl/nand_cycle_adapter.sv
module nand_cycle_adapter
  import nca_pkg::*;
#(
  parameter int AW         = 16,
  parameter int HOST_BYTES = 4,
  parameter int NUM_CS     = 4,
  parameter int ALE_BIT    = 3,
  parameter int CLE_BIT    = 4,
  parameter int SEC_BIT    = 14,
  parameter int SETUP      = 1,
  parameter int STROBE     = 2,
  parameter int HOLD       = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_valid,
  output logic                       host_ready,
  input  logic                       host_write,
  input  logic [1:0]                 host_size,
  input  logic [AW-1:0]              host_addr,
  input  logic [8*HOST_BYTES-1:0]    host_wdata,
  input  logic [$clog2(NUM_CS)-1:0]  host_cs,
  input  logic [1:0]                 host_chip,
  output logic                       host_rsp_valid,
  output logic [8*HOST_BYTES-1:0]    host_rdata,
  output logic [NUM_CS-1:0]          nand_ce_n,
  output logic                       nand_cle,
  output logic                       nand_ale,
  output logic                       nand_we_n,
  output logic                       nand_re_n,
  output logic [AW-1:0]              nand_addr,
  output logic [7:0]                 nand_dout,
  output logic                       nand_doe,
  input  logic [7:0]                 nand_din,
  input  logic                       nand_rb,
  output logic                       stat_ready
);
  localparam int HW  = 8 * HOST_BYTES;
  localparam int LW  = $clog2(HOST_BYTES);
  localparam int CSW = $clog2(NUM_CS);
  localparam logic [AW-1:0] SEC_MASK = AW'(1) << SEC_BIT;

  logic [AW-1:2]  a_waddr;
  logic [HW-1:0]  a_wdata;
  logic           a_write;
  logic [CSW-1:0] a_cs;
  logic           a_sec;
  logic [HW-1:0]  rdata_r;
  logic           rsp_r;

  phase_e         phase;
  logic [LW-1:0]  lane;
  logic           sample;
  logic           done;
  logic           active;
  logic           accept;
  logic [LW-1:0]  last_lane;
  latch_e         kind;

  logic unused_low;
  assign unused_low = ^host_addr[1:0];

  assign host_ready = (phase == PH_IDLE);
  assign accept     = host_valid && host_ready;
  assign active     = (phase != PH_IDLE);

  always_comb begin
    case (host_size)
      2'd0:    last_lane = '0;
      2'd1:    last_lane = (HOST_BYTES > 1) ? LW'(1) : '0;
      default: last_lane = LW'(HOST_BYTES - 1);
    endcase
  end

  nca_seq #(
    .HOST_BYTES(HOST_BYTES), .SETUP(SETUP), .STROBE(STROBE), .HOLD(HOLD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .last_in(last_lane),
    .phase(phase), .lane(lane), .sample(sample), .done(done)
  );

  nca_decode #(.AW(AW), .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT)) u_dec (
    .word_addr(a_waddr), .kind(kind)
  );

  nca_rb_sync u_rb (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .rb_sync(stat_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_waddr <= '0;
      a_wdata <= '0;
      a_write <= 1'b0;
      a_cs    <= '0;
      a_sec   <= 1'b0;
      rdata_r <= '0;
      rsp_r   <= 1'b0;
    end else begin
      rsp_r <= done;
      if (accept) begin
        a_waddr <= host_addr[AW-1:2];
        a_wdata <= host_wdata;
        a_write <= host_write;
        a_cs    <= host_cs;
        a_sec   <= (host_chip != 2'd0);
        rdata_r <= '0;
      end else if (sample && !a_write) begin
        rdata_r[8*int'(lane) +: 8] <= nand_din;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign nand_ce_n[g] = !(active && (a_cs == CSW'(g)));
  end

  assign nand_cle       = active && (kind == LAT_CMD);
  assign nand_ale       = active && (kind == LAT_ADDR);
  assign nand_we_n      = !((phase == PH_STROBE) && a_write);
  assign nand_re_n      = !((phase == PH_STROBE) && !a_write);
  assign nand_doe       = active && a_write;
  assign nand_dout      = a_wdata[8*int'(lane) +: 8];
  assign nand_addr      = active ? ({a_waddr, 2'b00} | (a_sec ? SEC_MASK : '0)) : '0;
  assign host_rdata     = rdata_r;
  assign host_rsp_valid = rsp_r;

  assert_latch_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_low_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nand_addr[1:0] == 2'b00);
  assert_ce_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  assert_ce_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(nand_ce_n));
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_wait_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_ce_n != '1) |-> !host_ready);
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> !host_rsp_valid);
  assert_rsp_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> host_ready);
endmodule

// File: tb/test_nand_cycle_adapter.sv
module test_nand_cycle_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SEC_BIT = 14;
  localparam int STROBE = 2;
  localparam int CYC_PER_BYTE = 4;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [1:0]  cs;
    logic [1:0]  chip;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 2'd2, 16'h0010, 32'h44332211, 2'd0, 2'd0},
    '{1'b1, 2'd0, 16'h0008, 32'h000000A5, 2'd1, 2'd0},
    '{1'b1, 2'd1, 16'h001B, 32'h0000BEEF, 2'd2, 2'd1},
    '{1'b1, 2'd2, 16'h0003, 32'hDEADBEEF, 2'd3, 2'd2},
    '{1'b0, 2'd2, 16'h0000, 32'h00000000, 2'd0, 2'd0},
    '{1'b0, 2'd1, 16'h0412, 32'h00000000, 2'd1, 2'd3},
    '{1'b0, 2'd0, 16'h0001, 32'h00000000, 2'd2, 2'd0},
    '{1'b1, 2'd3, 16'h000C, 32'h0A0B0C0D, 2'd1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  host_cs = '0;
  logic [1:0]  host_chip = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [15:0] nand_addr;
  logic [7:0]  nand_dout;
  logic [7:0]  nand_din;
  logic        nand_rb = 1'b1;
  logic        stat_ready;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rd_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign nand_din = 8'h3C + rd_total[7:0];

  nand_cycle_adapter #(
    .AW(AW), .HOST_BYTES(4), .NUM_CS(4), .ALE_BIT(3), .CLE_BIT(4),
    .SEC_BIT(SEC_BIT), .SETUP(1), .STROBE(STROBE), .HOLD(1)
  ) i_nand_cycle_adapter (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_size(host_size), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_cs(host_cs), .host_chip(host_chip),
    .host_rsp_valid(host_rsp_valid), .host_rdata(host_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_addr(nand_addr),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
    .nand_rb(nand_rb), .stat_ready(stat_ready)
  );

  // Flash-side monitor: records one entry per completed strobe
  logic       in_strobe = 1'b0;
  int         strobe_w = 0;
  int         cap_n = 0;
  logic [1:0] cur_lat;
  logic [3:0] cur_ce;
  logic [15:0] cur_addr;
  logic [7:0] cur_dout;
  logic       cur_rd, cur_doe;
  logic [1:0]  cap_lat  [0:7];
  logic [3:0]  cap_ce   [0:7];
  logic [15:0] cap_addr [0:7];
  logic [7:0]  cap_dout [0:7];
  logic        cap_rd   [0:7];
  logic        cap_doe  [0:7];
  int          cap_w    [0:7];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n || !nand_re_n) begin
        if (!in_strobe) strobe_w = 0;
        in_strobe = 1'b1;
        strobe_w  = strobe_w + 1;
        cur_lat   = {nand_cle, nand_ale};
        cur_ce    = nand_ce_n;
        cur_addr  = nand_addr;
        cur_dout  = nand_dout;
        cur_rd    = !nand_re_n;
        cur_doe   = nand_doe;
      end else if (in_strobe) begin
        in_strobe = 1'b0;
        if (cap_n < 8) begin
          cap_lat[cap_n]  = cur_lat;
          cap_ce[cap_n]   = cur_ce;
          cap_addr[cap_n] = cur_addr;
          cap_dout[cap_n] = cur_dout;
          cap_rd[cap_n]   = cur_rd;
          cap_doe[cap_n]  = cur_doe;
          cap_w[cap_n]    = strobe_w;
        end
        cap_n = cap_n + 1;
        if (cur_rd) rd_total = rd_total + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_lat(input logic [15:0] a);
    if (a[4])      return 2'b10;
    else if (a[3]) return 2'b01;
    else           return 2'b00;
  endfunction

  function automatic int exp_bytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic run_vec(input vec_t v);
    int n, waitc, base;
    logic rsp;
    logic [31:0] rd, exp_rd;
    logic [15:0] exp_addr;
    n = exp_bytes(v.size);
    @(negedge clk);
    host_write = v.wr; host_size = v.size; host_addr = v.addr;
    host_wdata = v.wdata; host_cs = v.cs; host_chip = v.chip;
    host_valid = 1'b1;
    cap_n = 0;
    base = rd_total;
    @(posedge clk);
    #1 host_valid = 1'b0;
    waitc = 0;
    @(negedge clk);
    while (!host_ready) begin
      waitc++;
      @(negedge clk);
    end
    rsp = host_rsp_valid;
    rd  = host_rdata;
    check(waitc == n * CYC_PER_BYTE, "R8 wait length", waitc, n * CYC_PER_BYTE);
    check(rsp == 1'b1, "R8 response pulse", rsp, 1);
    check(cap_n == n, "R3 byte cycle count", cap_n, n);
    exp_addr = {v.addr[15:2], 2'b00} | ((v.chip != 2'd0) ? 16'(1 << SEC_BIT) : 16'h0);
    exp_rd = '0;
    for (int i = 0; i < n && i < 8; i++) begin
      check(cap_lat[i] == exp_lat(v.addr), "R1 latch type", cap_lat[i], exp_lat(v.addr));
      check(cap_ce[i] == ~(4'b0001 << v.cs), "R4 chip enable", cap_ce[i], ~(4'b0001 << v.cs));
      check(cap_addr[i] == exp_addr, "R5 flash address", cap_addr[i], exp_addr);
      check(cap_addr[i][1:0] == 2'b00, "R2 low bits ignored", cap_addr[i][1:0], 0);
      check(cap_rd[i] == !v.wr, "R6 strobe kind", cap_rd[i], !v.wr);
      check(cap_doe[i] == v.wr, "R6 output enable", cap_doe[i], v.wr);
      check(cap_w[i] == STROBE, "R6 strobe width", cap_w[i], STROBE);
      if (v.wr)
        check(cap_dout[i] == v.wdata[8*i +: 8], "R3 byte lane order", cap_dout[i], v.wdata[8*i +: 8]);
      exp_rd[8*i +: 8] = 8'h3C + 8'(base + i);
    end
    if (!v.wr) check(rd == exp_rd, "R7 read assembly", rd, exp_rd);
    @(negedge clk);
    check(host_rsp_valid == 1'b0, "R8 single pulse", host_rsp_valid, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    summary();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check(host_ready == 1'b1, "R10 ready in reset", host_ready, 1);
    check(nand_ce_n == 4'hF, "R10 chip enables idle", nand_ce_n, 4'hF);
    check({nand_we_n, nand_re_n} == 2'b11, "R10 strobes idle", {nand_we_n, nand_re_n}, 2'b11);
    check({nand_cle, nand_ale, nand_doe, host_rsp_valid} == 4'b0,
          "R10 latches and response idle", {nand_cle, nand_ale, nand_doe, host_rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(stat_ready == 1'b1, "R9 ready reflected", stat_ready, 1);

    for (int k = 0; k < 8; k++) run_vec(VECS[k]);

    // R9: busy seen two edges later
    @(negedge clk);
    nand_rb = 1'b0;
    @(negedge clk);
    check(stat_ready == 1'b1, "R9 one edge after busy", stat_ready, 1);
    @(negedge clk);
    check(stat_ready == 1'b0, "R9 two edges after busy", stat_ready, 0);
    nand_rb = 1'b1;
    repeat (2) @(negedge clk);
    check(stat_ready == 1'b1, "R9 ready again", stat_ready, 1);

    // R2: same request differing only in low bits gives identical cycles
    run_vec('{1'b1, 2'd0, 16'h0017, 32'h0000007E, 2'd3, 2'd0});
    run_vec('{1'b1, 2'd0, 16'h0014, 32'h0000007E, 2'd3, 2'd0});

    // R4: idle after accesses
    check(nand_ce_n == 4'hF, "R4 idle chip enables", nand_ce_n, 4'hF);
    summary();
  end
endmodule